// File: doc/BRIEF.md
# Selectable Register Pair with Merging Scratch Register

This block holds the two general-purpose 8-bit registers of a small accumulator datapath, named A and C, plus a hidden 8-bit scratch register B. Only one of A and C is reachable during an instruction. Bit 6 of the current instruction byte selects it, and every read and write made in that instruction goes to the selected register.

The scratch register can load straight from the bus. It can also fold the bus value into the active register while it loads, storing either the AND or the OR of the two. Two further instruction bits choose the fold. These bits come from the instruction byte itself, not from the microword, so they stay in force for the whole instruction. The fold happens only on a scratch load. The arithmetic unit that consumes B and the active register is outside this block.

Top module: `regpair_scratch`

## Requirements
- R1: While rst_n is low, A, C and B are all 0x00, so act_q and scr_q read 0x00.
- R2: act_q shows A when instr bit 6 is 0 and C when instr bit 6 is 1.
- R3: A rising edge with ld_reg high writes bus_in only into the register chosen by instr bit 6. The other register keeps its value.
- R4: A rising edge with ld_scr high and instr bits 7 and 5 both 0 loads bus_in into B unchanged.
- R5: A rising edge with ld_scr high and instr bit 7 set loads bus_in AND the pre-edge active register into B.
- R6: A rising edge with ld_scr high, instr bit 5 set and bit 7 clear loads bus_in OR the pre-edge active register into B.
- R7: When instr bits 7 and 5 are both set, the AND fold is applied and the OR fold is not.
- R8: Without its load enable, each register holds its value across clock edges.
- R9: bus_out equals act_q when drv_reg is high. It equals scr_q when only drv_scr is high. It is 0x00 when neither is high. drv_reg wins when both are high.
- R10: When ld_reg and ld_scr are high at the same edge, B folds with the active register's value from before that edge, and the active register takes bus_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 8 | Current instruction byte (bit 7 AND fold, bit 6 register select, bit 5 OR fold) |
| bus_in | input | 8 | Data bus value |
| ld_reg | input | 1 | Load the selected general register from the bus |
| ld_scr | input | 1 | Load the scratch register (with optional fold) |
| drv_reg | input | 1 | Drive the active register onto bus_out |
| drv_scr | input | 1 | Drive the scratch register onto bus_out |
| bus_out | output | 8 | Value this block drives toward the bus |
| scr_q | output | 8 | Scratch register to the ALU |
| act_q | output | 8 | Active general register to the ALU |

## Verification
A scratch load with a fold and a write to the active register can land on the same edge. The fold must then use the register's old contents, not the byte arriving on the bus. The bench provokes this by raising ld_reg and ld_scr together across every fold mode and both register selections, with a bus byte that differs from the stored one. It judges the result against a model that samples the pre-edge register value, and then reads the register back to confirm it took the new byte.

// File: rtl/regpair_scratch.sv
module regpair_scratch #(
  parameter int W       = 8,
  parameter int IW      = 8,
  parameter int SEL_BIT = 6,
  parameter int AND_BIT = 7,
  parameter int OR_BIT  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  input  logic [W-1:0]  bus_in,
  input  logic          ld_reg,
  input  logic          ld_scr,
  input  logic          drv_reg,
  input  logic          drv_scr,
  output logic [W-1:0]  bus_out,
  output logic [W-1:0]  scr_q,
  output logic [W-1:0]  act_q
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] a_q, c_q, scr_d;
  logic         sel_c, use_and, use_or;

  assign sel_c   = instr[SEL_BIT];
  assign use_and = instr[AND_BIT];
  assign use_or  = instr[OR_BIT];

  assign act_q = sel_c ? c_q : a_q;

  always_comb begin
    if (use_and)     scr_d = bus_in & act_q;
    else if (use_or) scr_d = bus_in | act_q;
    else             scr_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= ZERO;
      c_q   <= ZERO;
      scr_q <= ZERO;
    end else begin
      if (ld_reg && !sel_c) a_q <= bus_in;
      if (ld_reg &&  sel_c) c_q <= bus_in;
      if (ld_scr)           scr_q <= scr_d;
    end
  end

  assign bus_out = drv_reg ? act_q : (drv_scr ? scr_q : ZERO);
endmodule

// File: rtl/regpair_scratch_chk.sv
module regpair_scratch_chk #(
  parameter int W       = 8,
  parameter int IW      = 8,
  parameter int SEL_BIT = 6,
  parameter int AND_BIT = 7,
  parameter int OR_BIT  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] instr,
  input logic [W-1:0]  bus_in,
  input logic          ld_reg,
  input logic          ld_scr,
  input logic          drv_reg,
  input logic          drv_scr,
  input logic [W-1:0]  bus_out,
  input logic [W-1:0]  scr_q,
  input logic [W-1:0]  act_q,
  input logic [W-1:0]  a_q,
  input logic [W-1:0]  c_q
);
  // R3
  unsel_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr[SEL_BIT] |=> $stable(c_q));
  // R3
  unsel_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[SEL_BIT] |=> $stable(a_q));
  // R4
  plain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_scr && !instr[AND_BIT] && !instr[OR_BIT]) |=> scr_q == $past(bus_in));
  // R5
  and_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_scr && instr[AND_BIT]) |=> scr_q == ($past(bus_in) & $past(act_q)));
  // R6
  or_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_scr && !instr[AND_BIT] && instr[OR_BIT]) |=> scr_q == ($past(bus_in) | $past(act_q)));
  // R8
  scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_scr |=> $stable(scr_q));
  // R9
  drv_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_reg |-> bus_out == act_q);
  // R9
  drv_scr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_reg && drv_scr) |-> bus_out == scr_q);
endmodule

bind regpair_scratch regpair_scratch_chk #(
  .W(W), .IW(IW), .SEL_BIT(SEL_BIT), .AND_BIT(AND_BIT), .OR_BIT(OR_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .instr(instr), .bus_in(bus_in),
  .ld_reg(ld_reg), .ld_scr(ld_scr), .drv_reg(drv_reg), .drv_scr(drv_scr),
  .bus_out(bus_out), .scr_q(scr_q), .act_q(act_q), .a_q(a_q), .c_q(c_q)
);

// File: tb/regpair_scratch_tb.sv
module regpair_scratch_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] instr = 0, bus_in = 0;
  logic       ld_reg = 0, ld_scr = 0, drv_reg = 0, drv_scr = 0;
  logic [7:0] bus_out, scr_q, act_q;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_a = 0, m_c = 0, m_b = 0;

  always #2 clk = ~clk;

  regpair_scratch dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .bus_in(bus_in),
    .ld_reg(ld_reg), .ld_scr(ld_scr), .drv_reg(drv_reg), .drv_scr(drv_scr),
    .bus_out(bus_out), .scr_q(scr_q), .act_q(act_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] active_m(input logic [7:0] ins);
    return ins[6] ? m_c : m_a;
  endfunction

  task automatic cyc(input logic [7:0] ins, input logic [7:0] b, input logic lr, input logic ls,
                     input logic dr, input logic ds, input string req);
    logic [7:0] old_act, exp_out;
    @(negedge clk);
    instr = ins; bus_in = b; ld_reg = lr; ld_scr = ls; drv_reg = dr; drv_scr = ds;
    @(posedge clk);
    old_act = active_m(ins);
    if (ls) begin
      if (ins[7])      m_b = b & old_act;
      else if (ins[5]) m_b = b | old_act;
      else             m_b = b;
    end
    if (lr) begin
      if (ins[6]) m_c = b; else m_a = b;
    end
    #1;
    exp_out = dr ? active_m(ins) : (ds ? m_b : 8'h00);
    check({req, " act"}, act_q, active_m(ins));
    check({req, " scr"}, scr_q, m_b);
    check({req, " bus (R9)"}, bus_out, exp_out);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1
    instr = 8'h00; #0; check("R1 A", act_q, 8'h00);
    instr = 8'h40; #0; check("R1 C", act_q, 8'h00);
    check("R1 B", scr_q, 8'h00);
    rst_n = 1;

    // R2 / R3: write each side, then read both
    cyc(8'h00, 8'h5A, 1, 0, 0, 0, "R3 write A");
    cyc(8'h40, 8'hA5, 1, 0, 0, 0, "R3 write C");
    cyc(8'h00, 8'hFF, 0, 0, 1, 0, "R2 read A");
    check("R3 A kept", act_q, 8'h5A);
    cyc(8'h40, 8'hFF, 0, 0, 1, 0, "R2 read C");
    check("R3 C kept", act_q, 8'hA5);
    // R8: no loads, values hold
    cyc(8'h00, 8'h33, 0, 0, 0, 1, "R8 hold");
    check("R8 B held", scr_q, 8'h00);

    // R4 R5 R6 R7 sweep across both selections and all fold modes
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int v = 0; v < 8; v++)
          for (int b = 0; b < 256; b++) begin
            logic [7:0] ins;
            ins = {m[1], s[0], m[0], 5'b00011};
            cyc(ins, 8'(v * 37 + 11), 1, 0, (b % 3) == 0, (b % 2) == 0, "R3 seed");
            cyc(ins, 8'(b), 0, 1, (b % 5) == 0, 1,
                m == 0 ? "R4 plain" : (m == 2 ? "R5 and" : (m == 1 ? "R6 or" : "R7 both")));
          end

    // R10: simultaneous register write and scratch fold
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 256; b += 7) begin
          logic [7:0] ins;
          ins = {m[1], s[0], m[0], 5'b00100};
          cyc(ins, 8'hC3 ^ 8'(b * 3), 1, 0, 0, 0, "R10 seed");
          cyc(ins, 8'(b), 1, 1, 0, 1, "R10 same edge");
          cyc(ins, 8'h00, 0, 0, 1, 0, "R10 readback");
        end

    // R9 both drivers: register wins
    cyc(8'h40, 8'h00, 0, 0, 1, 1, "R9 priority");

    // R1 again mid-run
    @(negedge clk); rst_n = 0; #1;
    m_a = 0; m_c = 0; m_b = 0;
    instr = 8'h00; #0; check("R1 A rerst", act_q, 8'h00);
    check("R1 B rerst", scr_q, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule